// File: doc/BRIEF.md
# Laser-Driver Register Shadow Sequencer

This block sits on the master side of a 3-wire serial link to an external laser-driver chip. It keeps that chip in step with a bank of local shadow registers. Three events start a full update pass: supply power reported valid for the first time, a temperature-conversion-done pulse, and a rising edge of the transmit-disable input. A pass copies every writable control shadow to the slave, reads the two transmitter status registers back into the shadow bank, and then zeroes the slave's bias and modulation setting registers. Each frame drives chip select 1 alone or both chip selects, depending on the register address.

A host loads the shadow bank through a simple write port. When the block is idle the host can also issue single manual reads or writes through a valid/ready request channel. Each manual request produces one response beat on a valid/ready response channel. The request channel applies back-pressure by holding `man_ready` low while a pass runs, while a pass is pending, or while an earlier response has not been taken. The response channel holds `rsp_valid` and `rsp_data` steady until the host asserts `rsp_ready`. Shadow slot 13h, which has no slave register, holds the low LOS threshold. The slave's own register 04h holds whichever threshold `los_sel` selects.

Top module: `ldd_shadow_seq`

## Requirements
- R1: The first rising edge of `pwr_ok` after reset starts a pass (`pwr_ok` already high when reset is released counts as rising). Later rising edges of `pwr_ok` start nothing.
- R2: A one-cycle `tconv_done` pulse starts a pass. A low-to-high change of `txdis` starts a pass. A falling `txdis`, or `txdis` held high through reset, does not.
- R3: A pass is 24 frames in this order: writes of shadow slot N to slave address N for N = 00h..19h in ascending order, skipping 02h, 06h, 07h, 08h, 09h and 13h; then reads of 06h and 07h; then writes of 00h to 08h and 09h. Address 13h is never accessed.
- R4: In a pass, addresses 00h–04h, 0Eh, 12h and 14h–17h assert both `cs1_n` and `cs2_n` (active low). All other addresses assert `cs1_n` only.
- R5: The write to slave address 04h carries shadow slot 04h (high threshold) when `los_sel`=0 and shadow slot 13h (low threshold) when `los_sel`=1.
- R6: The bytes read from 06h and 07h are stored in shadow slots 06h and 07h and appear on `stat1` and `stat2` once the pass ends.
- R7: Any number of triggers arriving during a pass collapse into exactly one further pass. That pass starts right after the current one, with `busy` staying high.
- R8: A frame is 16 bits, sent MSB first: a R/W bit (1 = read), a 7-bit address, then 8 data bits. `sclk` idles low. `sdo` changes only after a falling `sclk`, and the slave samples on the rising edge. `sdo_oe` is low during the 8 data bits of a read, and the slave's `sdi` is captured on the rising `sclk`. `cs1_n` stays high for at least 2 clock cycles (one `sclk` period) between frames.
- R9: `busy` rises within 2 cycles of a trigger seen while idle. It falls in the same cycle that `cs1_n` releases after the last frame of the last pass.
- R10: A manual request is taken when `man_valid` and `man_ready` are both high. `man_ready` is high only while no pass is running or pending, no trigger is present and no response is waiting. A manual frame asserts both chip selects at any address.
- R11: Every manual request returns one response. `rsp_data` is the byte read for a read and 00h for a write. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen.
- R12: After reset: `busy`=0, `cs1_n`=`cs2_n`=1, `sclk`=0, `sdo_oe`=0, `rsp_valid`=0, `man_ready`=1, and `stat1`=`stat2`=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply valid level |
| tconv_done | input | 1 | Temperature conversion done pulse |
| txdis | input | 1 | Transmit disable level |
| los_sel | input | 1 | Threshold select for slave address 04h (1 = low) |
| shd_we | input | 1 | Host shadow write strobe |
| shd_addr | input | 5 | Host shadow slot index |
| shd_wdata | input | 8 | Host shadow write data |
| man_valid | input | 1 | Manual request valid |
| man_ready | output | 1 | Manual request ready |
| man_rw | input | 1 | Manual request direction (1 = read) |
| man_addr | input | 7 | Manual request slave address |
| man_wdata | input | 8 | Manual request write data |
| rsp_valid | output | 1 | Manual response valid |
| rsp_ready | input | 1 | Manual response ready |
| rsp_data | output | 8 | Manual response data |
| busy | output | 1 | Update pass in progress |
| stat1 | output | 8 | Shadowed transmitter status 1 (slave 06h) |
| stat2 | output | 8 | Shadowed transmitter status 2 (slave 07h) |
| sclk | output | 1 | Serial clock |
| cs1_n | output | 1 | Chip select 1, active low |
| cs2_n | output | 1 | Chip select 2, active low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data in from slave |

## Verification
The assertions assume that `rsp_ready` may be held low for any length of time, that `tconv_done` arrives as isolated single-cycle pulses, and that `sdi` matters only during the data bits of a read frame. The link properties (chip-select nesting, `sclk` idle low, `sdo` steady while `sclk` is high, the inter-frame gap) depend on nothing but the design's own outputs. The bench's slave model drives `sdi` only after a falling `sclk` in the data phase of read frames. The bench pulses triggers for one cycle on the falling clock edge, and it randomizes shadow contents, status bytes, manual addresses and response stall lengths from a fixed seed.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int SHW = 5;
  localparam int NSH = 1 << SHW;
  localparam int FB = 1 + AW + DW;

  localparam logic [AW-1:0] TOP_CTRL = 7'h19;
  localparam logic [AW-1:0] A_THR    = 7'h04;
  localparam logic [AW-1:0] A_ST1    = 7'h06;
  localparam logic [AW-1:0] A_ST2    = 7'h07;
  localparam logic [AW-1:0] A_BIAS   = 7'h08;
  localparam logic [AW-1:0] A_MOD    = 7'h09;
  localparam logic [AW-1:0] A_HOLE   = 7'h13;

  // control registers replayed from the shadow bank
  function automatic logic is_ctrl(input logic [AW-1:0] a);
    return (a <= TOP_CTRL) && (a != 7'h02) && (a != A_HOLE) &&
           !((a >= A_ST1) && (a <= A_MOD));
  endfunction

  // receiver-side and shared registers take both selects
  function automatic logic both_cs(input logic [AW-1:0] a);
    return (a <= A_THR) || (a == 7'h0E) || (a == 7'h12) ||
           ((a >= 7'h14) && (a <= 7'h17));
  endfunction

  function automatic int count_ctrl();
    int n;
    n = 0;
    for (int a = 0; a <= int'(TOP_CTRL); a++)
      if (is_ctrl(AW'(a))) n++;
    return n;
  endfunction

  localparam int N_CTRL  = count_ctrl();
  localparam int N_STEPS = N_CTRL + 4;
  localparam int STW     = $clog2(N_STEPS);

  typedef enum logic [1:0] {K_COPY, K_READ, K_ZERO} step_kind_t;

  typedef struct packed {
    logic          rw;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          both;
  } frame_req_t;

  function automatic logic [AW-1:0] step_addr(input logic [STW-1:0] idx);
    logic [AW-1:0] r;
    int n;
    r = '0;
    n = 0;
    if (int'(idx) >= N_CTRL) begin
      case (int'(idx) - N_CTRL)
        0:       r = A_ST1;
        1:       r = A_ST2;
        2:       r = A_BIAS;
        default: r = A_MOD;
      endcase
    end else begin
      for (int a = 0; a <= int'(TOP_CTRL); a++) begin
        if (is_ctrl(AW'(a))) begin
          if (n == int'(idx)) r = AW'(a);
          n++;
        end
      end
    end
    return r;
  endfunction

  function automatic step_kind_t step_kind(input logic [STW-1:0] idx);
    if (int'(idx) < N_CTRL) return K_COPY;
    if (int'(idx) < N_CTRL + 2) return K_READ;
    return K_ZERO;
  endfunction
endpackage

// File: rtl/ldd_trig.sv
module ldd_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic tconv_done,
  input  logic txdis,
  output logic trig
);
  logic pwr_q, pwr_seen, txd_q;
  logic pwr_evt, txd_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= 1'b0;
      pwr_seen <= 1'b0;
      txd_q    <= 1'b1;   // txdis already high at reset is not an edge
    end else begin
      pwr_q <= pwr_ok;
      txd_q <= txdis;
      if (pwr_evt) pwr_seen <= 1'b1;
    end
  end

  assign pwr_evt = pwr_ok && !pwr_q && !pwr_seen;
  assign txd_evt = txdis && !txd_q;
  assign trig    = pwr_evt || tconv_done || txd_evt;
endmodule

// File: rtl/ldd_shadow.sv
module ldd_shadow
  import ldd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [SHW-1:0] host_addr,
  input  logic [DW-1:0]  host_data,
  input  logic           cap_we,
  input  logic [SHW-1:0] cap_addr,
  input  logic [DW-1:0]  cap_data,
  input  logic [SHW-1:0] rd_addr,
  input  logic           los_sel,
  output logic [DW-1:0]  rd_data,
  output logic [DW-1:0]  stat1,
  output logic [DW-1:0]  stat2
);
  logic [DW-1:0] mem [NSH];
  logic [SHW-1:0] rd_idx;

  for (genvar g = 0; g < NSH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (cap_we && cap_addr == SHW'(g))
        mem[g] <= cap_data;
      else if (host_we && host_addr == SHW'(g))
        mem[g] <= host_data;
    end
  end

  // slot 13h holds the low threshold; it replaces slot 04h when selected
  assign rd_idx  = (los_sel && rd_addr == A_THR[SHW-1:0]) ? A_HOLE[SHW-1:0] : rd_addr;
  assign rd_data = mem[rd_idx];
  assign stat1   = mem[A_ST1[SHW-1:0]];
  assign stat2   = mem[A_ST2[SHW-1:0]];
endmodule

// File: rtl/ldd_serial.sv
module ldd_serial
  import ldd_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  frame_req_t    req,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          sclk,
  output logic          cs1_n,
  output logic          cs2_n,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          sdi
);
  localparam int BW = $clog2(FB);
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} est_t;
  est_t st;
  logic [FB-1:0] sh;
  logic [BW-1:0] bitc;
  logic          ph, rd_frame, both_q;
  logic [GW-1:0] gcnt;
  logic          last_bit, in_data;

  assign last_bit = bitc == BW'(FB - 1);
  assign in_data  = bitc >= BW'(1 + AW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      sh       <= '0;
      bitc     <= '0;
      ph       <= 1'b0;
      rd_frame <= 1'b0;
      both_q   <= 1'b0;
      gcnt     <= '0;
      rdata    <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          sh       <= {req.rw, req.addr, req.data};
          rd_frame <= req.rw;
          both_q   <= req.both;
          bitc     <= '0;
          ph       <= 1'b0;
          rdata    <= '0;
          st       <= E_SHIFT;
        end
        E_SHIFT: begin
          if (!ph) begin
            ph <= 1'b1;                       // sclk rises next
            if (rd_frame && in_data) rdata <= {rdata[DW-2:0], sdi};
          end else begin
            ph <= 1'b0;                       // sclk falls, data moves
            if (last_bit) begin
              st   <= E_GAP;
              gcnt <= '0;
            end else begin
              bitc <= bitc + 1'b1;
              sh   <= {sh[FB-2:0], 1'b0};
            end
          end
        end
        E_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) st <= E_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign idle   = st == E_IDLE;
  assign done   = (st == E_SHIFT) && ph && last_bit;
  assign sclk   = (st == E_SHIFT) && ph;
  assign cs1_n  = !(st == E_SHIFT);
  assign cs2_n  = !((st == E_SHIFT) && both_q);
  assign sdo    = sh[FB-1];
  assign sdo_oe = (st == E_SHIFT) && !(rd_frame && in_data);
endmodule

// File: rtl/ldd_shadow_seq.sv
module ldd_shadow_seq
  import ldd_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_ok,
  input  logic           tconv_done,
  input  logic           txdis,
  input  logic           los_sel,
  input  logic           shd_we,
  input  logic [SHW-1:0] shd_addr,
  input  logic [DW-1:0]  shd_wdata,
  input  logic           man_valid,
  output logic           man_ready,
  input  logic           man_rw,
  input  logic [AW-1:0]  man_addr,
  input  logic [DW-1:0]  man_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic           busy,
  output logic [DW-1:0]  stat1,
  output logic [DW-1:0]  stat2,
  output logic           sclk,
  output logic           cs1_n,
  output logic           cs2_n,
  output logic           sdo,
  output logic           sdo_oe,
  input  logic           sdi
);
  typedef enum logic [1:0] {Q_IDLE, Q_RUN, Q_MAN} qst_t;

  qst_t           q;
  logic [STW-1:0] step;
  logic           waiting, pend, man_rw_q;
  logic           trig;
  logic [AW-1:0]  cur_addr;
  step_kind_t     kind;
  logic           is_last;
  logic [DW-1:0]  shd_rd;
  frame_req_t     pass_req, man_req, eng_req;
  logic           eng_start, eng_idle, eng_done;
  logic [DW-1:0]  eng_rdata;
  logic           man_fire, cap_we;

  ldd_trig u_trig (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tconv_done(tconv_done),
    .txdis(txdis), .trig(trig)
  );

  assign cur_addr = step_addr(step);
  assign kind     = step_kind(step);
  assign is_last  = step == STW'(N_STEPS - 1);
  assign cap_we   = (q == Q_RUN) && eng_done && (kind == K_READ);

  ldd_shadow u_shadow (
    .clk(clk), .rst_n(rst_n),
    .host_we(shd_we), .host_addr(shd_addr), .host_data(shd_wdata),
    .cap_we(cap_we), .cap_addr(cur_addr[SHW-1:0]), .cap_data(eng_rdata),
    .rd_addr(cur_addr[SHW-1:0]), .los_sel(los_sel), .rd_data(shd_rd),
    .stat1(stat1), .stat2(stat2)
  );

  always_comb begin
    pass_req.rw   = kind == K_READ;
    pass_req.addr = cur_addr;
    pass_req.data = (kind == K_COPY) ? shd_rd : '0;
    pass_req.both = both_cs(cur_addr);
    man_req.rw    = man_rw;
    man_req.addr  = man_addr;
    man_req.data  = man_rw ? '0 : man_wdata;
    man_req.both  = 1'b1;                     // manual frames use both selects
  end

  assign man_ready = (q == Q_IDLE) && !pend && !trig && !rsp_valid && eng_idle;
  assign man_fire  = man_valid && man_ready;
  assign eng_start = ((q == Q_RUN) && !waiting && eng_idle) || man_fire;
  assign eng_req   = (q == Q_RUN) ? pass_req : man_req;
  assign busy      = q == Q_RUN;

  ldd_serial #(.GAP_CYC(GAP_CYC)) u_serial (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .req(eng_req),
    .idle(eng_idle), .done(eng_done), .rdata(eng_rdata),
    .sclk(sclk), .cs1_n(cs1_n), .cs2_n(cs2_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdi(sdi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= Q_IDLE;
      step     <= '0;
      waiting  <= 1'b0;
      pend     <= 1'b0;
      man_rw_q <= 1'b0;
    end else begin
      case (q)
        Q_IDLE: begin
          if (trig || pend) begin
            q       <= Q_RUN;
            step    <= '0;
            waiting <= 1'b0;
            pend    <= 1'b0;
          end else if (man_fire) begin
            q        <= Q_MAN;
            man_rw_q <= man_rw;
          end
        end
        Q_RUN: begin
          if (eng_start) waiting <= 1'b1;
          if (eng_done) begin
            waiting <= 1'b0;
            step    <= step + 1'b1;
          end
          if (eng_done && is_last) begin
            step <= '0;
            pend <= 1'b0;
            if (!(trig || pend)) q <= Q_IDLE;   // else replay at once
          end else if (trig) begin
            pend <= 1'b1;
          end
        end
        Q_MAN: begin
          if (trig) pend <= 1'b1;
          if (eng_done) q <= Q_IDLE;
        end
        default: q <= Q_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if ((q == Q_MAN) && eng_done) begin
      rsp_valid <= 1'b1;
      rsp_data  <= man_rw_q ? eng_rdata : '0;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ldd_shadow_seq_chk.sv
module ldd_shadow_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       man_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       sclk,
  input logic       cs1_n,
  input logic       cs2_n,
  input logic       sdo,
  input logic       sdo_oe
);
  AST_CS2_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs2_n |-> !cs1_n);                                                    // R4
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_n |-> !sclk);                                                      // R8
  AST_SDO_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs1_n && $past(!cs1_n) && !$fell(sclk)) |-> $stable(sdo));           // R8
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !cs1_n);                                                    // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs1_n) |=> cs1_n ##1 cs1_n);                                     // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));       // R11
  AST_NO_MAN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    man_ready |-> (!busy && !rsp_valid));                                  // R10
endmodule

bind ldd_shadow_seq ldd_shadow_seq_chk chk_i (.*);

// File: tb/ldd_shadow_seq_tb_top.sv
module ldd_shadow_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 0, tconv_done = 0, txdis = 0, los_sel = 0;
  logic shd_we = 0; logic [4:0] shd_addr = 0; logic [7:0] shd_wdata = 0;
  logic man_valid = 0, man_rw = 0; logic [6:0] man_addr = 0; logic [7:0] man_wdata = 0;
  logic rsp_ready = 0, sdi = 0;
  logic man_ready, rsp_valid, busy, sclk, cs1_n, cs2_n, sdo, sdo_oe;
  logic [7:0] rsp_data, stat1, stat2;

  always #2.5 clk = ~clk;

  ldd_shadow_seq dut_i (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [7:0] sl_mem [0:127];
  logic [7:0] sl_st1 = 0, sl_st2 = 0;
  logic [15:0] s_sh; int s_cnt; logic s_rw; logic [6:0] s_addr; logic [7:0] s_rd; logic s_cs2;
  logic [15:0] lf [0:127]; logic lcs2 [0:127]; int nlog = 0;
  int oe_bad = 0, gap_bad = 0; realtime t_rel = -100.0;

  function automatic logic [7:0] sl_val(input logic [6:0] a);
    if (a == 7'h06) return sl_st1;
    if (a == 7'h07) return sl_st2;
    return sl_mem[a];
  endfunction

  initial for (int i = 0; i < 128; i++) sl_mem[i] = 8'h00;

  always @(negedge cs1_n) begin
    s_cnt = 0; s_sh = 0;
    if ($realtime - t_rel < 9.9) gap_bad++;
  end
  always @(posedge sclk) begin
    if (s_cnt >= 8 && s_rw && sdo_oe) oe_bad++;
    s_sh = {s_sh[14:0], sdo};
    s_cnt++;
    if (s_cnt == 1) s_cs2 = !cs2_n;
    if (s_cnt == 8) begin s_rw = s_sh[7]; s_addr = s_sh[6:0]; s_rd = sl_val(s_sh[6:0]); end
  end
  always @(negedge sclk) if (s_cnt >= 8 && s_cnt < 16 && s_rw) sdi <= s_rd[15 - s_cnt];
  always @(posedge cs1_n) begin
    t_rel = $realtime;
    if (s_cnt == 16) begin
      lf[nlog]   = {s_rw, s_addr, s_rw ? s_rd : s_sh[7:0]};
      lcs2[nlog] = s_cs2;
      if (!s_rw) sl_mem[s_addr] = s_sh[7:0];
      nlog++;
    end
  end

  // ---------------- bench expectations ----------------
  logic [7:0] bsh [0:31];

  function automatic bit b_ctrl(input int a);
    return a <= 'h19 && a != 'h02 && a != 'h13 && !(a >= 'h06 && a <= 'h09);
  endfunction
  function automatic bit b_both(input int a);
    return a <= 4 || a == 'h0E || a == 'h12 || (a >= 'h14 && a <= 'h17);
  endfunction
  function automatic int b_addr(input int i);
    int n = 0;
    if (i == 20) return 'h06;
    if (i == 21) return 'h07;
    if (i == 22) return 'h08;
    if (i == 23) return 'h09;
    for (int a = 0; a <= 'h19; a++) if (b_ctrl(a)) begin if (n == i) return a; n++; end
    return -1;
  endfunction

  task automatic step_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk); shd_we = 1; shd_addr = 5'(a); shd_wdata = d;
    @(negedge clk); shd_we = 0; bsh[a] = d;
  endtask

  task automatic wait_pass(input string tag);
    int k;
    k = 0;
    while (!busy && k < 3) begin @(negedge clk); k++; end
    chk(busy, {tag, " R9 busy rises"}, busy, 1);
    k = 0;
    while (busy && k < 4000) begin @(negedge clk); k++; if (!busy) chk(cs1_n, "R9 cs released with busy", cs1_n, 1); end
    step_n(4);
  endtask

  task automatic check_pass(input int base, input bit sel, input logic [7:0] st1, input logic [7:0] st2);
    for (int i = 0; i < 24; i++) begin
      int a; logic [7:0] d; logic rw;
      a  = b_addr(i);
      rw = (i == 20 || i == 21);
      if (i >= 22) d = 8'h00;
      else if (i == 20) d = st1;
      else if (i == 21) d = st2;
      else if (a == 4) d = sel ? bsh['h13] : bsh[4];
      else d = bsh[a];
      chk(lf[base+i][15:8] == {rw, 7'(a)}, "R3 frame rw/addr", int'(lf[base+i][15:8]), int'({rw, 7'(a)}));
      chk(lf[base+i][7:0] == d, (a == 4) ? "R5 threshold data" : "R3 frame data", int'(lf[base+i][7:0]), int'(d));
      chk(lcs2[base+i] == b_both(a), "R4 chip select", int'(lcs2[base+i]), int'(b_both(a)));
    end
  endtask

  task automatic pulse_tconv(); @(negedge clk); tconv_done = 1; @(negedge clk); tconv_done = 0; endtask

  task automatic man_xfer(input bit rw, input logic [6:0] a, input logic [7:0] d, input int stall);
    logic [7:0] exp; logic [7:0] held;
    exp = rw ? sl_val(a) : 8'h00;
    nlog = 0;
    @(negedge clk); man_valid = 1; man_rw = rw; man_addr = a; man_wdata = d;
    while (!man_ready) @(negedge clk);
    @(negedge clk); man_valid = 0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held && !man_ready, "R11 response held", int'(rsp_valid), 1);
    end
    chk(rsp_data == exp, "R11 response data", int'(rsp_data), int'(exp));
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    chk(!rsp_valid, "R11 response taken", int'(rsp_valid), 0);
    step_n(3);
    chk(nlog == 1 && lf[0] == {rw, a, rw ? exp : d}, "R10 manual frame", int'(lf[0]), int'({rw, a, rw ? exp : d}));
    chk(lcs2[0] == 1'b1, "R10 manual both selects", int'(lcs2[0]), 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(150000 * 5);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] st1, st2;
    void'($urandom(32'h1A5E_D00D));
    for (int i = 0; i < 32; i++) bsh[i] = 8'h00;
    step_n(3);
    rst_n = 1;
    step_n(2);
    chk(!busy && cs1_n && cs2_n && !sclk && !sdo_oe && !rsp_valid, "R12 reset outputs", int'({busy, cs1_n, cs2_n, sclk, sdo_oe, rsp_valid}), 'b011000);
    chk(man_ready && stat1 == 0 && stat2 == 0, "R12 reset ready/stat", int'({man_ready, stat1, stat2}), 'h10000);

    for (int i = 0; i < 32; i++) host_wr(i, 8'($urandom));
    host_wr('h13, 8'hC3); host_wr(4, 8'h3C);

    // R1: first power-valid edge
    st1 = 8'($urandom); st2 = 8'($urandom); sl_st1 = st1; sl_st2 = st2;
    nlog = 0;
    @(negedge clk); pwr_ok = 1;
    wait_pass("R1");
    chk(nlog == 24, "R1 pass frame count", nlog, 24);
    check_pass(0, 0, st1, st2);
    chk(stat1 == st1 && stat2 == st2, "R6 status shadow", int'({stat1, stat2}), int'({st1, st2}));
    chk(oe_bad == 0 && gap_bad == 0, "R8 oe/gap", oe_bad + gap_bad, 0);

    // R1: later power edges ignored
    nlog = 0;
    @(negedge clk); pwr_ok = 0; step_n(5); pwr_ok = 1; step_n(80);
    chk(nlog == 0 && !busy, "R1 second power edge ignored", nlog, 0);

    // R5: low threshold select, temperature trigger
    los_sel = 1;
    st1 = 8'($urandom); st2 = 8'($urandom); sl_st1 = st1; sl_st2 = st2;
    nlog = 0; pulse_tconv();
    wait_pass("R2");
    chk(nlog == 24, "R2 tconv pass count", nlog, 24);
    check_pass(0, 1, st1, st2);
    chk(stat1 == st1 && stat2 == st2, "R6 status updated", int'({stat1, stat2}), int'({st1, st2}));

    // R2: txdis edges
    los_sel = 0; host_wr(4, 8'($urandom));
    nlog = 0; @(negedge clk); txdis = 1;
    wait_pass("R2");
    chk(nlog == 24, "R2 txdis rise pass", nlog, 24);
    check_pass(0, 0, st1, st2);
    nlog = 0; @(negedge clk); txdis = 0; step_n(80);
    chk(nlog == 0 && !busy, "R2 txdis fall ignored", nlog, 0);

    // R7: collapse of triggers during a pass
    nlog = 0; pulse_tconv();
    step_n(40);
    pulse_tconv(); step_n(7); pulse_tconv(); @(negedge clk); txdis = 1; step_n(3);
    @(negedge clk); man_valid = 1; man_rw = 1; man_addr = 7'h20;
    step_n(2);
    chk(!man_ready, "R10 no manual while busy", int'(man_ready), 0);
    @(negedge clk); man_valid = 0;
    begin
      int k, drops;
      k = 0; drops = 0;
      while (busy && k < 8000) begin
        @(negedge clk); k++;
        if (!busy) drops++;
      end
      step_n(4);
      chk(nlog == 48, "R7 exactly two passes", nlog, 48);
      chk(drops == 1 && !busy, "R7 busy continuous", drops, 1);
    end
    check_pass(0, 0, st1, st2);
    check_pass(24, 0, st1, st2);
    txdis = 0; step_n(4);

    // R10/R11: random manual traffic
    for (int i = 0; i < 12; i++) begin
      bit rw; logic [6:0] a;
      rw = 1'($urandom);
      a  = 7'($urandom);
      man_xfer(rw, a, 8'($urandom), int'($urandom % 6));
    end
    man_xfer(1, 7'h06, 8'h00, 0);
    man_xfer(0, 7'h13, 8'h5A, 2);
    chk(oe_bad == 0 && gap_bad == 0, "R8 oe/gap final", oe_bad + gap_bad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule